// File: doc/BRIEF.md
# Multiplexed SAR ADC Host Controller

This block sits on the host side of a serial, eight-input successive-approximation converter. The converter is reached through four wires: one convert/select line, a shift clock, a line that carries the configuration word into the converter, and a line that carries the result back. The convert line does two jobs. Its rising edge starts a conversion, and while it is low it frames a serial transfer. In every transfer the controller shifts a 7-bit configuration word out and a 16-bit result in at the same time.

A client hands the controller one request at a time: input channel, single-ended or differential input, use of the common pin as the minus input, unipolar or bipolar coding, and a sleep request. The converter uses a configuration word for the conversion that starts when the transfer carrying that word ends. Each result therefore belongs to the word sent in the transfer before. The controller tags every result with the word that produced it. It also raises a stale flag when that word differs from the one just requested, when no word had been sent since reset, or when the conversion ran during sleep or wake-up. The controller enforces the conversion time, the acquisition time, the sample-rate limit, the wake-up delay and the shift-clock ceiling, all counted in system clock cycles.

Top module: `madc_host_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, the convert line is high, the shift clock is low, `req_ready` is 0 and `res_valid` is 0. A conversion time of CONV_CYC cycles is counted from reset before the first request is accepted.
- R2: The configuration word goes out MSB first, one bit per shift-clock rising edge, in the first 7 of the 16 clock pulses. Its bits, from first sent to last, are: single-ended flag (1 when `req_diff`=0), `req_chan[0]`, `req_chan[2]`, `req_chan[1]`, `req_com`, unipolar flag (1 when `req_bipolar`=0), `req_sleep`.
- R3: The 16-bit result is captured MSB first on shift-clock rising edges. It appears unchanged on `res_data`, with `res_valid` high for exactly one cycle per transfer.
- R4: The convert line stays high for at least CONV_CYC cycles after each rising edge (and after reset) before it falls. `req_ready` is only high while the line is high and that time has passed.
- R5: Two rising edges of the convert line are at least PERIOD_CYC cycles apart. The line stays low for at least ACQ_CYC cycles before each rising edge.
- R6: Each low phase of the convert line holds exactly 16 shift-clock pulses. The shift clock is low whenever the convert line is high. The line rises again only after the 16th pulse.
- R7: Each shift-clock level lasts max(SCK_HALF, ceil(SYS_MHZ/80)) system cycles, so the shift clock never exceeds 40 MHz.
- R8: `res_cfg` carries the word sent in the previous transfer, or 0 for the first transfer after reset. `res_stale` is 1 for the first result after reset and whenever `res_cfg` differs from the word sent in the current transfer.
- R9: A result whose tag has the sleep bit set is stale. After a transfer that clears sleep while the converter was asleep, the next transfer starts at least WAKE_CYC cycles after the following rising edge, and that conversion's result is stale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_chan | input | 3 | Channel number (plus input) |
| req_diff | input | 1 | 1: differential pair, 0: single-ended |
| req_com | input | 1 | 1: common pin used as minus input |
| req_bipolar | input | 1 | 1: bipolar coding, 0: unipolar |
| req_sleep | input | 1 | 1: put the converter to sleep |
| adc_conv | output | 1 | Convert start / transfer frame line |
| adc_sck | output | 1 | Shift clock |
| adc_sdi | output | 1 | Configuration bits to the converter |
| adc_sdo | input | 1 | Result bits from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Result word as received |
| res_cfg | output | 7 | Configuration word that produced the result |
| res_stale | output | 1 | Result does not match the current request |

## Verification
A wrong sequencer state shows at the ports within one transfer. The convert line then falls early or rises early, or the shift-clock pulse count in the frame is not 16, and each of these is caught at the next edge of the convert line. A wrong shift register or bit counter corrupts the configuration bits seen by the converter model, or the returned result, in the same transfer. A wrong tag or sleep history shows one transfer later as a wrong `res_cfg` or `res_stale`, or as a missing wake-up delay in the high phase before the following transfer.

// File: rtl/madc_pkg.sv
// Shared types and helpers for the multiplexed SAR ADC host controller.
// Assumes the converter's 7-bit configuration word and 16-bit result.
package madc_pkg;
    localparam int CFG_W   = 7;
    localparam int RES_W   = 16;
    localparam int CH_W    = 3;
    localparam int SLP_POS = 0;   // sleep bit is the last one shifted out

    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic            diff;
        logic            use_com;
        logic            bipolar;
        logic            sleep;
    } madc_req_t;

    typedef enum logic [1:0] {
        ST_CONV,   // line high, conversion or wake-up running
        ST_IDLE,   // line high, ready for a request
        ST_FRAME,  // line low, bits shifting
        ST_HOLD    // line low, waiting out acquisition and rate limit
    } madc_state_t;

    // Order is fixed by the converter's input shift register.
    function automatic logic [CFG_W-1:0] madc_pack_word(input madc_req_t r);
        return {~r.diff, r.chan[0], r.chan[2], r.chan[1],
                r.use_com, ~r.bipolar, r.sleep};
    endfunction
endpackage

// File: rtl/madc_interval.sv
// Down-counting interval timer. Loads LOAD on request and reports done at 0.
// Assumes LOAD >= 1; RST_FULL selects whether reset starts a full interval.
module madc_interval #(
    parameter int unsigned LOAD     = 16,
    parameter bit          RST_FULL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int W = $clog2(LOAD + 1);

    logic [W-1:0] cnt;

    // Count down to zero, reloading on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= RST_FULL ? W'(LOAD) : '0;
        else if (load)
            cnt <= W'(LOAD);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/madc_shifter.sv
// Full-duplex bit shifter for one frame: drives the shift clock, sends the
// configuration word MSB first and captures RES_W result bits on rising edges.
// Assumes start only arrives while idle; each clock level lasts HALF cycles.
module madc_shifter #(
    parameter int HALF  = 3,
    parameter int CFG_W = 7,
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CFG_W-1:0] word,
    input  logic             sdo,
    output logic             sck,
    output logic             sdi,
    output logic [RES_W-1:0] rx_data,
    output logic             done
);
    localparam int CW  = $clog2(HALF + 1);
    localparam int BW  = $clog2(RES_W);
    localparam int PAD = RES_W - CFG_W;

    logic             busy;
    logic [CW-1:0]    cnt;
    logic [BW-1:0]    bidx;
    logic [RES_W-1:0] tx;

    // Step the clock phases, shift out on falls and capture on rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sck     <= 1'b0;
            cnt     <= '0;
            bidx    <= '0;
            tx      <= '0;
            rx_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy <= 1'b1;
                sck  <= 1'b0;
                cnt  <= '0;
                bidx <= '0;
                tx   <= {word, {PAD{1'b0}}};
            end else if (busy) begin
                if (cnt == CW'(HALF - 1)) begin
                    cnt <= '0;
                    if (!sck) begin
                        sck     <= 1'b1;
                        rx_data <= {rx_data[RES_W-2:0], sdo};
                    end else begin
                        sck <= 1'b0;
                        if (bidx == BW'(RES_W - 1)) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            bidx <= bidx + 1'b1;
                            tx   <= {tx[RES_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign sdi = busy & tx[RES_W-1];
endmodule

// File: rtl/madc_seq.sv
// Convert-line sequencer: holds the line high through conversion and wake-up,
// accepts one request, frames the transfer, then waits out acquisition time
// and the rate limit before the rising edge that starts the next conversion.
module madc_seq import madc_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic conv_done,
    input  logic wake_done,
    input  logic acq_done,
    input  logic period_done,
    input  logic frame_done,
    output logic conv,
    output logic req_ready,
    output logic start,
    output logic rise
);
    madc_state_t st;

    // Decode handshake and line-rise conditions from the state.
    always_comb begin
        req_ready = (st == ST_IDLE);
        start     = req_ready && req_valid;
        rise      = (st == ST_HOLD) && acq_done && period_done;
    end

    // Advance the state and drive the convert line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_CONV;
            conv <= 1'b1;
        end else begin
            case (st)
                ST_CONV:  if (conv_done && wake_done) st <= ST_IDLE;
                ST_IDLE:  if (start) begin
                              st   <= ST_FRAME;
                              conv <= 1'b0;
                          end
                ST_FRAME: if (frame_done) st <= ST_HOLD;
                ST_HOLD:  if (rise) begin
                              st   <= ST_CONV;
                              conv <= 1'b1;
                          end
                default:  st <= ST_CONV;
            endcase
        end
    end
endmodule

// File: rtl/madc_tagger.sv
// Result tagging: remembers which word configured the running conversion,
// tracks sleep and wake-up history, and publishes each result with its tag
// and a stale flag. Assumes frame_done follows every start.
module madc_tagger import madc_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CFG_W-1:0] word,
    input  logic             frame_done,
    input  logic [RES_W-1:0] rx_data,
    input  logic             conv_rise,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic [CFG_W-1:0] res_cfg,
    output logic             res_stale,
    output logic             waking
);
    logic [CFG_W-1:0] cur_word;
    logic [CFG_W-1:0] tag;
    logic             tag_ok;
    logic             tag_bad;
    logic             asleep;
    logic             cur_slp;

    assign cur_slp = cur_word[SLP_POS];

    // Latch the word of the transfer in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)     cur_word <= '0;
        else if (start) cur_word <= word;
    end

    // Publish the result and roll the tag over to the new word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_cfg   <= '0;
            res_stale <= 1'b0;
            tag       <= '0;
            tag_ok    <= 1'b0;
            tag_bad   <= 1'b0;
            asleep    <= 1'b0;
        end else begin
            res_valid <= frame_done;
            if (frame_done) begin
                res_data  <= rx_data;
                res_cfg   <= tag;
                res_stale <= !tag_ok || tag_bad || (tag != cur_word);
                tag       <= cur_word;
                tag_ok    <= 1'b1;
                tag_bad   <= cur_slp || (asleep && !cur_slp);
                asleep    <= cur_slp;
            end
        end
    end

    // Flag that the coming rising edge ends a sleep period.
    always_ff @(posedge clk) begin
        if (!rst_n)          waking <= 1'b0;
        else if (frame_done) waking <= asleep && !cur_slp;
        else if (conv_rise)  waking <= 1'b0;
    end
endmodule

// File: rtl/madc_host_ctrl.sv
// Host controller for a serial multiplexed SAR ADC. Builds the configuration
// word from a request, runs conversion/transfer timing in system cycles and
// returns tagged results. Assumes adc_sdo is stable around shift-clock rises
// and that SYS_MHZ is the system clock rate in MHz.
module madc_host_ctrl import madc_pkg::*; #(
    parameter int unsigned SYS_MHZ    = 200,
    parameter int unsigned SCK_HALF   = 3,
    parameter int unsigned CONV_CYC   = 700,
    parameter int unsigned ACQ_CYC    = 300,
    parameter int unsigned PERIOD_CYC = 1000,
    parameter int unsigned WAKE_CYC   = 12_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [CH_W-1:0]  req_chan,
    input  logic             req_diff,
    input  logic             req_com,
    input  logic             req_bipolar,
    input  logic             req_sleep,
    output logic             adc_conv,
    output logic             adc_sck,
    output logic             adc_sdi,
    input  logic             adc_sdo,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic [CFG_W-1:0] res_cfg,
    output logic             res_stale
);
    // Shortest legal half period keeps the shift clock at or below 40 MHz.
    localparam int unsigned MIN_HALF = (SYS_MHZ + 79) / 80;
    localparam int unsigned EFF_HALF = (SCK_HALF < MIN_HALF) ? MIN_HALF : SCK_HALF;

    madc_req_t        req;
    logic [CFG_W-1:0] word;
    logic             start, rise, frame_done, waking;
    logic             conv_done, period_done, acq_done, wake_done;
    logic [RES_W-1:0] rx_data;

    // Gather request fields into the configuration word.
    always_comb begin
        req.chan    = req_chan;
        req.diff    = req_diff;
        req.use_com = req_com;
        req.bipolar = req_bipolar;
        req.sleep   = req_sleep;
        word        = madc_pack_word(req);
    end

    madc_interval #(.LOAD(CONV_CYC), .RST_FULL(1'b1)) u_conv_tmr (
        .clk(clk), .rst_n(rst_n), .load(rise), .done(conv_done));
    madc_interval #(.LOAD(PERIOD_CYC), .RST_FULL(1'b1)) u_period_tmr (
        .clk(clk), .rst_n(rst_n), .load(rise), .done(period_done));
    madc_interval #(.LOAD(ACQ_CYC), .RST_FULL(1'b0)) u_acq_tmr (
        .clk(clk), .rst_n(rst_n), .load(start), .done(acq_done));
    madc_interval #(.LOAD(WAKE_CYC), .RST_FULL(1'b0)) u_wake_tmr (
        .clk(clk), .rst_n(rst_n), .load(rise && waking), .done(wake_done));

    madc_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .conv_done(conv_done), .wake_done(wake_done), .acq_done(acq_done),
        .period_done(period_done), .frame_done(frame_done),
        .conv(adc_conv), .req_ready(req_ready), .start(start), .rise(rise));

    madc_shifter #(.HALF(EFF_HALF), .CFG_W(CFG_W), .RES_W(RES_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .word(word), .sdo(adc_sdo),
        .sck(adc_sck), .sdi(adc_sdi), .rx_data(rx_data), .done(frame_done));

    madc_tagger u_tag (
        .clk(clk), .rst_n(rst_n), .start(start), .word(word),
        .frame_done(frame_done), .rx_data(rx_data), .conv_rise(rise),
        .res_valid(res_valid), .res_data(res_data), .res_cfg(res_cfg),
        .res_stale(res_stale), .waking(waking));
endmodule

// File: rtl/madc_host_ctrl_chk.sv
// Protocol checker bound to the controller: measures line phases with its
// own counters and checks timing, pulse counts and strobe shape.
module madc_host_ctrl_chk #(
    parameter int unsigned CONV_CYC   = 700,
    parameter int unsigned ACQ_CYC    = 300,
    parameter int unsigned PERIOD_CYC = 1000,
    parameter int unsigned RES_W      = 16
) (
    input logic clk,
    input logic rst_n,
    input logic adc_conv,
    input logic adc_sck,
    input logic req_ready,
    input logic res_valid
);
    localparam logic [31:0] SAT = 32'h7fff_ffff;

    logic        conv_d, sck_d, conv_rise;
    logic [31:0] hi_cnt, lo_cnt, rr_cnt, n_rise;

    assign conv_rise = adc_conv && !conv_d;

    // Count cycles per line phase, between rises, and clock pulses per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_d <= 1'b1;
            sck_d  <= 1'b0;
            hi_cnt <= '0;
            lo_cnt <= '0;
            rr_cnt <= '0;
            n_rise <= '0;
        end else begin
            conv_d <= adc_conv;
            sck_d  <= adc_sck;
            hi_cnt <= adc_conv ? ((hi_cnt < SAT) ? hi_cnt + 1 : hi_cnt) : '0;
            lo_cnt <= adc_conv ? '0 : ((lo_cnt < SAT) ? lo_cnt + 1 : lo_cnt);
            rr_cnt <= conv_rise ? 32'd1 : ((rr_cnt < SAT) ? rr_cnt + 1 : rr_cnt);
            n_rise <= conv_rise ? '0 : ((adc_sck && !sck_d) ? n_rise + 1 : n_rise);
        end
    end

    p_conv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_conv) |-> hi_cnt >= CONV_CYC);
    p_ready_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (adc_conv && hi_cnt >= CONV_CYC));
    p_rate_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_rise |-> rr_cnt >= PERIOD_CYC);
    p_acq_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_rise |-> lo_cnt >= ACQ_CYC);
    p_sck_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_conv |-> !adc_sck);
    p_pulse_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_rise |-> n_rise == RES_W);
    p_strobe_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
endmodule

bind madc_host_ctrl madc_host_ctrl_chk #(
    .CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC), .PERIOD_CYC(PERIOD_CYC),
    .RES_W(madc_pkg::RES_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .adc_conv(adc_conv), .adc_sck(adc_sck),
    .req_ready(req_ready), .res_valid(res_valid)
);

// File: tb/sim_madc_host_ctrl.sv
`timescale 1ns/1ps
module sim_madc_host_ctrl;
    localparam int CONV   = 40;
    localparam int ACQ    = 120;
    localparam int PERIOD = 300;
    localparam int WAKE   = 500;
    localparam int HALF_X = 3;   // requested 1, floor at 200 MHz is 3

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_diff = 1'b0, req_com = 1'b0;
    logic req_bipolar = 1'b0, req_sleep = 1'b0;
    logic [2:0] req_chan = '0;
    logic req_ready, adc_conv, adc_sck, adc_sdi, adc_sdo;
    logic res_valid, res_stale;
    logic [15:0] res_data;
    logic [6:0]  res_cfg;

    int vecs = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    madc_host_ctrl #(
        .SYS_MHZ(200), .SCK_HALF(1), .CONV_CYC(CONV), .ACQ_CYC(ACQ),
        .PERIOD_CYC(PERIOD), .WAKE_CYC(WAKE)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_diff(req_diff), .req_com(req_com),
        .req_bipolar(req_bipolar), .req_sleep(req_sleep),
        .adc_conv(adc_conv), .adc_sck(adc_sck), .adc_sdi(adc_sdi),
        .adc_sdo(adc_sdo), .res_valid(res_valid), .res_data(res_data),
        .res_cfg(res_cfg), .res_stale(res_stale));

    // Converter model: result = {9'h12D, word active at conversion start}.
    logic [15:0] m_sh = '0;
    logic [6:0]  m_rx = '0, m_word = '0, m_conv_word = '0;
    int          m_nbits = 0;
    assign adc_sdo = m_sh[15];
    always @(posedge adc_conv) m_conv_word = m_word;
    always @(negedge adc_conv) begin m_sh = {9'h12D, m_conv_word}; m_nbits = 0; end
    always @(posedge adc_sck) if (!adc_conv) begin
        if (m_nbits < 7) m_rx = {m_rx[5:0], adc_sdi};
        m_nbits++;
        if (m_nbits == 7) m_word = m_rx;
    end
    always @(negedge adc_sck) if (!adc_conv) m_sh = {m_sh[14:0], 1'b0};

    // Line phase measurement.
    logic pc_conv = 1'b1, pc_sck = 1'b0;
    int run = 0, rr = 0, last_hi = 0, last_lo = 0, last_rr = 0;
    int rises = 0, last_rises = 0, sck_run = 0, last_sck_hi = 0, sck_lo_run = 0, last_sck_lo = 0;
    always @(posedge clk) begin
        if (adc_conv !== pc_conv) begin
            if (adc_conv) begin
                last_lo = run; last_rises = rises; rises = 0; last_rr = rr; rr = 0;
            end else last_hi = run;
            run = 0;
        end
        run++; rr++;
        if (adc_sck && !pc_sck) begin rises++; if (rises > 1) last_sck_lo = sck_lo_run; end
        if (adc_sck) begin sck_run++; sck_lo_run = 0; end
        else begin
            if (pc_sck) begin last_sck_hi = sck_run; sck_run = 0; end
            sck_lo_run++;
        end
        pc_conv = adc_conv; pc_sck = adc_sck;
    end

    task automatic chk(input string what, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic chk_ge(input string what, input int act, input int lim);
        vecs++;
        if (act < lim) begin
            fails++;
            $display("FAIL %s actual=%0d expected>=%0d", what, act, lim);
        end
    endtask

    function automatic logic [6:0] exp_word(input logic [2:0] ch, input logic d,
                                            input logic c, input logic b, input logic s);
        return {~d, ch[0], ch[2], ch[1], c, ~b, s};
    endfunction

    // Bench-side history for tags and staleness.
    logic [6:0] b_prev = '0;
    logic b_first = 1'b1, b_bad = 1'b0, b_asleep = 1'b0;

    task automatic do_xfer(input logic [2:0] ch, input logic d, input logic c,
                           input logic b, input logic s);
        logic [6:0] w;
        logic [15:0] got_data;
        logic [6:0]  got_cfg;
        logic        got_stale;
        w = exp_word(ch, d, c, b, s);
        do @(negedge clk); while (!req_ready);
        req_chan = ch; req_diff = d; req_com = c; req_bipolar = b; req_sleep = s;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        do @(negedge clk); while (!res_valid);
        got_data = res_data; got_cfg = res_cfg; got_stale = res_stale;
        chk("R2 word seen by converter", int'(m_word), int'(w));
        chk("R3 result data", int'(got_data), int'({9'h12D, b_prev}));
        chk("R8 result tag", int'(got_cfg), int'(b_prev));
        chk("R8 R9 stale flag", int'(got_stale),
            int'(b_first || b_bad || (b_prev != w)));
        b_bad = s || (b_asleep && !s);
        b_asleep = s; b_prev = w; b_first = 1'b0;
        do @(negedge clk); while (!adc_conv);
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        chk("R1 conv high in reset", int'(adc_conv), 1);
        chk("R1 sck low in reset", int'(adc_sck), 0);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        chk("R1 conv high after reset", int'(adc_conv), 1);
        chk("R1 ready low after reset", int'(req_ready), 0);
        chk("R1 valid low after reset", int'(res_valid), 0);
    endtask

    task automatic t_patterns;
        do_xfer(3'd5, 1'b0, 1'b0, 1'b0, 1'b0);   // first after reset: stale
        do_xfer(3'd2, 1'b1, 1'b1, 1'b1, 1'b0);
        do_xfer(3'd7, 1'b0, 1'b1, 1'b1, 1'b0);
        do_xfer(3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        do_xfer(3'd6, 1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_timing;
        do_xfer(3'd3, 1'b0, 1'b0, 1'b1, 1'b0);
        chk_ge("R4 convert high time", last_hi, CONV);
        chk_ge("R5 rise spacing", last_rr, PERIOD);
        chk_ge("R5 low time", last_lo, ACQ);
        chk("R6 pulses per frame", last_rises, 16);
        chk("R6 sck low with conv high", int'(adc_sck), 0);
        chk("R7 sck high width", last_sck_hi, HALF_X);
        chk("R7 sck low width", last_sck_lo, HALF_X);
    endtask

    task automatic t_repeat;
        do_xfer(3'd4, 1'b1, 1'b0, 1'b0, 1'b0);
        do_xfer(3'd4, 1'b1, 1'b0, 1'b0, 1'b0);   // R8 same word: not stale
        chk("R8 repeat tag matches", int'(res_cfg), int'(exp_word(3'd4, 1'b1, 1'b0, 1'b0, 1'b0)));
    endtask

    task automatic t_sleep;
        do_xfer(3'd0, 1'b0, 1'b0, 1'b0, 1'b1);   // go to sleep
        do_xfer(3'd0, 1'b0, 1'b0, 1'b0, 1'b0);   // R9 tag has sleep bit: stale
        do_xfer(3'd0, 1'b0, 1'b0, 1'b0, 1'b0);   // R9 warming result: stale
        chk_ge("R9 wake delay before frame", last_hi, WAKE);
        do_xfer(3'd0, 1'b0, 1'b0, 1'b0, 1'b0);   // settled: fresh
        chk("R9 settled result fresh", int'(res_stale), 0);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset_state();
        t_patterns();
        t_timing();
        t_repeat();
        t_sleep();
        finish_run();
    end
endmodule